// File: doc/BRIEF.md
# Sampling Converter Serial Readout Port

This block is the device-side digital front end of a 16-bit sampling converter. A host lowers an active-low chip select to end the acquisition phase. The block then sends a one-cycle request to the converter core, and the core answers with a valid strobe and the conversion word. The host supplies a serial clock and reads the word on a data line. That line is tri-stated while the device is deselected. It is enabled and held low as a start marker on the fifth falling clock edge. It then carries the word most significant bit first. After the last bit it is held low until the host deselects.

The chip select and serial clock are sampled in the system clock domain. Both are assumed to be synchronous to it or already synchronized, and the serial clock must be slow enough that each of its levels lasts at least one system clock. A falling edge counts when the previous sample was high and the present input is low. The tri-state buffer sits outside the block and is driven from the `sdo_oe` enable. A power-down indicator is raised once the core has delivered its result, and it falls when the host deselects and the device returns to tracking the input.

The control state machine has five states. IDLE means deselected or acquiring. LEAD counts the first four clock falls. MARK holds the low marker. SHIFT sends the data bits. TAIL holds the line low after the LSB. The transitions are:
- IDLE to LEAD on a chip-select fall.
- LEAD to MARK on the fifth clock fall.
- MARK to SHIFT on the next fall.
- SHIFT to TAIL on the fall after the LSB.
- Any state to IDLE whenever chip select is high.

Top module: `adc_serial_port`

## Requirements
- R1: Whenever `cs_n` is high, `sdo_oe` is 0 from the next system clock edge onward.
- R2: A falling edge of `cs_n` produces `conv_start` high for exactly one system clock and starts a new frame with its edge count at zero.
- R3: During a frame, `sdo_oe` stays 0 through the first four falling edges of `sclk`. On the fifth falling edge, `sdo_oe` becomes 1 and `sdo` is 0.
- R4: On falling edges 6 to 21 of a frame, `sdo` carries the captured 16-bit word, bit 15 first and bit 0 last.
- R5: From falling edge 22 until `cs_n` rises, `sdo_oe` is 1 and `sdo` is 0.
- R6: If `cs_n` rises part-way through a frame, the output is tri-stated on the next clock. The following frame starts from edge one and sends its own word correctly.
- R7: Falling edges of `sclk` while `cs_n` is high have no effect. `sdo_oe`, `conv_start` and `pwr_down` stay 0, and the next frame still places its marker on the fifth edge.
- R8: `res_data` is captured on the first `res_valid` pulse in a frame, up to and including the clock of the sixth `sclk` fall. If no result has arrived by then, `late_data` is set, the 16 data bits are sent as zeros, and any later `res_valid` in that frame is ignored. `late_data` stays set until the next `cs_n` fall clears it.
- R9: `pwr_down` is 1 from the capture of a result until `cs_n` rises. It is 0 when no result was captured in the frame.
- R10: After reset, `sdo_oe`, `sdo`, `conv_start`, `pwr_down` and `late_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host; falling edges are counted |
| res_valid | input | 1 | Result-ready strobe from the converter core |
| res_data | input | DATA_W | Conversion word from the converter core |
| conv_start | output | 1 | One-cycle conversion request to the core |
| sdo | output | 1 | Serial data toward the tri-state pad |
| sdo_oe | output | 1 | Output enable for the pad; 0 means high impedance |
| pwr_down | output | 1 | Converter core may power down |
| late_data | output | 1 | Result missed the deadline for the first data bit |

## Verification
The hardest situation to reach is the result deadline. The pulse of `res_valid` has to land exactly one serial-clock fall before the first data bit, or exactly one fall after it. The stimulus table therefore gives, for each frame, the edge number after which the core's strobe is injected. This places on-time deliveries at edge 5 and earlier and a late delivery at edge 6, and one frame never delivers at all. Aborted frames and clock activity while deselected are driven as separate directed sequences. Each is followed by a normal frame that must show the marker and the data in the right place.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_MARK,
        ST_SHIFT,
        ST_TAIL
    } port_state_e;

endpackage

// File: rtl/lvl_fall_det.sv
module lvl_fall_det #(
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic fall
);

    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= RST_LVL;
        else        sig_q <= sig;
    end

    assign fall = sig_q & ~sig;

endmodule

// File: rtl/result_capture.sv
module result_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              clr,
    input  logic              deadline,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    output logic [DATA_W-1:0] word,
    output logic              held,
    output logic              late
);

    logic              open_q;
    logic              have_q;
    logic              late_q;
    logic [DATA_W-1:0] res_q;
    logic              take;

    assign take = open_q && res_valid && !have_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            have_q <= 1'b0;
            late_q <= 1'b0;
            res_q  <= '0;
        end else if (clr) begin
            open_q <= 1'b0;
            have_q <= 1'b0;
        end else if (arm) begin
            open_q <= 1'b1;
            have_q <= 1'b0;
            late_q <= 1'b0;
        end else begin
            if (take) begin
                have_q <= 1'b1;
                res_q  <= res_data;
            end
            if (deadline) begin
                open_q <= 1'b0;
                if (!have_q && !take) late_q <= 1'b1;
            end
        end
    end

    always_comb begin
        if (have_q)    word = res_q;
        else if (take) word = res_data;
        else           word = '0;
    end

    assign held = have_q;
    assign late = late_q;

    // R8
    late_blocks_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (late_q && !arm) |=> !have_q);

    // R8
    late_only_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(late_q) |-> !have_q);

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import ser_port_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int LEAD_EDGES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    output logic              conv_start,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              pwr_down,
    output logic              late_data
);

    localparam int LEAD_W = $clog2(LEAD_EDGES + 1);
    localparam int BIT_W  = $clog2(DATA_W);
    localparam logic [LEAD_W-1:0] LEAD_LAST = LEAD_W'(LEAD_EDGES - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(DATA_W - 1);

    port_state_e       state, nxt;
    logic              cs_fall, sclk_fall, deadline;
    logic [LEAD_W-1:0] lead_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] word;
    logic              held;

    lvl_fall_det #(.RST_LVL(1'b1)) i_cs_det (
        .clk(clk), .rst_n(rst_n), .sig(cs_n), .fall(cs_fall)
    );

    lvl_fall_det #(.RST_LVL(1'b1)) i_sclk_det (
        .clk(clk), .rst_n(rst_n), .sig(sclk), .fall(sclk_fall)
    );

    assign deadline = !cs_n && (state == ST_MARK) && sclk_fall;

    result_capture #(.DATA_W(DATA_W)) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (cs_fall),
        .clr       (cs_n),
        .deadline  (deadline),
        .res_valid (res_valid),
        .res_data  (res_data),
        .word      (word),
        .held      (held),
        .late      (late_data)
    );

    assign pwr_down = held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (cs_n) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (cs_fall) nxt = ST_LEAD;
                ST_LEAD:  if (sclk_fall && lead_cnt == LEAD_LAST) nxt = ST_MARK;
                ST_MARK:  if (sclk_fall) nxt = ST_SHIFT;
                ST_SHIFT: if (sclk_fall && bit_cnt == BIT_LAST) nxt = ST_TAIL;
                ST_TAIL:  nxt = ST_TAIL;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            sdo        <= 1'b0;
            sdo_oe     <= 1'b0;
            lead_cnt   <= '0;
            bit_cnt    <= '0;
            shreg      <= '0;
        end else begin
            conv_start <= 1'b0;
            if (cs_n) begin
                sdo      <= 1'b0;
                sdo_oe   <= 1'b0;
                lead_cnt <= '0;
                bit_cnt  <= '0;
                shreg    <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (cs_fall) begin
                            conv_start <= 1'b1;
                            lead_cnt   <= '0;
                            bit_cnt    <= '0;
                        end
                    end
                    ST_LEAD: begin
                        if (sclk_fall) begin
                            if (lead_cnt == LEAD_LAST) begin
                                sdo_oe <= 1'b1;
                                sdo    <= 1'b0;
                            end else begin
                                lead_cnt <= lead_cnt + LEAD_W'(1);
                            end
                        end
                    end
                    ST_MARK: begin
                        if (sclk_fall) begin
                            sdo     <= word[DATA_W-1];
                            shreg   <= {word[DATA_W-2:0], 1'b0};
                            bit_cnt <= '0;
                        end
                    end
                    ST_SHIFT: begin
                        if (sclk_fall) begin
                            if (bit_cnt == BIT_LAST) begin
                                sdo <= 1'b0;
                            end else begin
                                sdo     <= shreg[DATA_W-1];
                                shreg   <= {shreg[DATA_W-2:0], 1'b0};
                                bit_cnt <= bit_cnt + BIT_W'(1);
                            end
                        end
                    end
                    ST_TAIL: sdo <= 1'b0;
                    default: sdo <= 1'b0;
                endcase
            end
        end
    end

    // R1
    hiz_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_oe);

    // R2
    conv_start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R3
    marker_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !sdo);

    // R4
    shift_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> sdo_oe);

    // R5
    tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |-> (sdo_oe && !sdo));

    // R9
    pwr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !pwr_down);

endmodule

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic        conv_start, sdo, sdo_oe, pwr_down, late_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adc_serial_port #(.DATA_W(16), .LEAD_EDGES(5)) i_adc_serial_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .res_valid(res_valid), .res_data(res_data),
        .conv_start(conv_start), .sdo(sdo), .sdo_oe(sdo_oe),
        .pwr_down(pwr_down), .late_data(late_data)
    );

    // stimulus vectors: {word, edge after which the core answers (30 = never)}
    localparam logic [20:0] VEC [6] = '{
        {16'hA5C3, 5'd0}, {16'hFFFF, 5'd3}, {16'h0000, 5'd5},
        {16'h8001, 5'd2}, {16'h7FFE, 5'd6}, {16'h1234, 5'd30}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edge_fall(output logic oe, output logic d);
        sclk = 1'b0;
        @(negedge clk);
        oe = sdo_oe;
        d  = sdo;
        sclk = 1'b1;
        @(negedge clk);
    endtask

    task automatic deliver(input logic [15:0] v);
        res_valid = 1'b1;
        res_data  = v;
        @(negedge clk);
        res_valid = 1'b0;
        res_data  = '0;
    endtask

    task automatic run_frame(input logic [15:0] v, input int k, input string tag);
        logic oe, d, mark_oe, mark_d;
        logic [15:0] got;
        int pre_oe;
        int tail_bad;
        logic late_exp;
        pre_oe = 0;
        tail_bad = 0;
        got = '0;
        mark_oe = 1'b0;
        mark_d = 1'b1;
        late_exp = (k >= 6);
        cs_n = 1'b0;
        @(negedge clk);
        chk({tag, " R2 conv_start pulse"}, 32'(conv_start), 32'd1);
        chk({tag, " R8 late cleared at select"}, 32'(late_data), 32'd0);
        if (k == 0) deliver(v);
        for (int e = 1; e <= 24; e++) begin
            edge_fall(oe, d);
            if (e < 5) pre_oe += int'(oe);
            else if (e == 5) begin mark_oe = oe; mark_d = d; end
            else if (e <= 21) got[21-e] = d;
            else if (!(oe === 1'b1 && d === 1'b0)) tail_bad++;
            if (e == k) deliver(v);
        end
        chk({tag, " R3 no enable before edge 5"}, 32'(pre_oe), 32'd0);
        chk({tag, " R3 marker at edge 5"}, {30'd0, mark_oe, mark_d}, 32'h2);
        chk({tag, " R4 serial word"}, 32'(got), late_exp ? 32'd0 : 32'(v));
        chk({tag, " R5 tail held low"}, 32'(tail_bad), 32'd0);
        chk({tag, " R8 late flag"}, 32'(late_data), 32'(late_exp));
        chk({tag, " R9 power down during frame"}, 32'(pwr_down), 32'(!late_exp));
        cs_n = 1'b1;
        @(negedge clk);
        chk({tag, " R1 hi-z after deselect"}, 32'(sdo_oe), 32'd0);
        chk({tag, " R9 power down released"}, 32'(pwr_down), 32'd0);
    endtask

    initial begin
        logic oe, d;
        int oe_sum;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 sdo_oe", 32'(sdo_oe), 32'd0);
        chk("R10 sdo", 32'(sdo), 32'd0);
        chk("R10 conv_start", 32'(conv_start), 32'd0);
        chk("R10 pwr_down", 32'(pwr_down), 32'd0);
        chk("R10 late_data", 32'(late_data), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 6; i++)
            run_frame(VEC[i][20:5], int'(VEC[i][4:0]), "VEC");

        // R6 abort part-way through the data bits
        cs_n = 1'b0;
        @(negedge clk);
        deliver(16'hDEAD);
        for (int e = 1; e <= 10; e++) edge_fall(oe, d);
        chk("R6 enabled mid frame", 32'(sdo_oe), 32'd1);
        chk("R9 held mid frame", 32'(pwr_down), 32'd1);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R6 hi-z on abort", 32'(sdo_oe), 32'd0);
        chk("R6 power down released on abort", 32'(pwr_down), 32'd0);
        run_frame(16'h0F0F, 1, "R6 restart");

        // R7 clock edges while deselected
        oe_sum = 0;
        for (int e = 0; e < 8; e++) begin
            edge_fall(oe, d);
            oe_sum += int'(oe) + int'(conv_start) + int'(pwr_down);
        end
        chk("R7 idle edges ignored", 32'(oe_sum), 32'd0);
        run_frame(16'h3C3C, 4, "R7 after idle edges");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule